// File: doc/BRIEF.md
# Byte-synchronous serial receiver with sync hunt and error recovery

This block receives a serial synchronous bit stream qualified by a bit-enable strobe. While it is hunting it looks for a programmable sync pattern of 4, 8 or 16 bits. In the mode that uses no pattern, it waits for a strobe on an external sync input instead. Once it is synchronised, it packs every following group of eight bits into a byte and checks odd parity over all eight bits, which are seven data bits and one parity bit. Each byte goes into a two-entry queue, and the downstream side drains that queue through a valid/ready interface.

A frame ends only on an error: carrier loss, queue overrun or a parity error. When that happens the block raises a one-cycle close pulse with exactly one cause flag, and a receive interrupt pulse if interrupts are enabled. It then goes straight back to hunting. A saturating counter with a synchronous clear keeps a tally of parity errors.

Output back-pressure works as follows. A byte is moved out in any cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head byte and its status stay fixed. Incoming bits are never stalled. If a byte completes while both entries are full and nothing is being popped, the newest entry is replaced and the frame closes with an overrun.

Top module: `bsync_rx`

## Requirements
- R1: After reset, `out_valid`, `frm_close`, `rx_irq` and `par_cnt` are all 0 and the receiver is hunting.
- R2: For `sync_mode` 01, 10 and 11, the receiver synchronises on the low 4, 8 or 16 bits of `sync_pat`. Bit 0 of the pattern arrives first on the line. A match counts only while `carrier` is high and only once that many bits have arrived since the last entry into hunting. The first data bit is the bit after the last pattern bit.
- R3: With `sync_mode` 00, the line pattern is ignored. A cycle in which `ext_sync` is high while hunting with `carrier` high starts reception, and the next strobed bit is data bit 0.
- R4: Bytes are assembled least significant bit first from eight strobed bits. Each byte appears at the queue output no earlier than the cycle after its eighth strobe.
- R5: The output queue holds two entries. The head stays stable while `out_valid` is high and `out_ready` is low, and it is removed on a cycle where both are high.
- R6: With `par_en` high, a byte with an even number of ones is still delivered, with `out_perr`=1. The frame then closes with `frm_par`, the counter increments and hunting resumes. With `par_en` low, `out_perr` is 0 and no parity close occurs.
- R7: A byte that completes while both entries are full and no pop happens replaces the newest entry, leaving the head untouched. The frame closes with `frm_ov` and hunting resumes.
- R8: Low `carrier` while receiving closes the frame in the next cycle with `frm_cd`, discards the partial byte and resumes hunting. This cause wins over an overrun or parity error on the same edge.
- R9: `frm_close` lasts one cycle and carries exactly one of `frm_cd`, `frm_ov` and `frm_par`. All three flags are 0 when there is no close.
- R10: `rx_irq` pulses together with `frm_close` when `int_en` was high at the error, and stays low otherwise.
- R11: `par_cnt` saturates at all ones. `par_cnt_clr` clears it on the next edge.
- R12: After any close, no byte is delivered until a fresh sync event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe marking a valid line bit |
| rx_bit | input | 1 | Serial data bit |
| carrier | input | 1 | Carrier present |
| ext_sync | input | 1 | External sync strobe (mode 00) |
| sync_mode | input | 2 | 00 external, 01 short, 10 mid, 11 full pattern |
| sync_pat | input | PAT_W | Sync pattern, bit 0 first on the line |
| par_en | input | 1 | Enable odd parity check |
| int_en | input | 1 | Enable receive interrupt pulse |
| par_cnt_clr | input | 1 | Clear parity error counter |
| out_valid | output | 1 | Head byte available |
| out_ready | input | 1 | Downstream accepts head byte |
| out_data | output | 8 | Head byte |
| out_perr | output | 1 | Head byte failed parity |
| frm_close | output | 1 | Frame closed by an error |
| frm_cd | output | 1 | Close cause: carrier lost |
| frm_ov | output | 1 | Close cause: overrun |
| frm_par | output | 1 | Close cause: parity error |
| rx_irq | output | 1 | Receive interrupt pulse |
| par_cnt | output | CNT_W | Parity error count |

## Verification
The hardest case to reach is carrier loss on the very strobe that completes a byte, when that byte would also overrun a full queue and fail parity. The stimulus holds `out_ready` low to fill both entries. It then sends a byte with bad parity and lowers `carrier` in the same cycle as that byte's eighth strobe. The scoreboard expects only the two earlier bytes and a close that shows only the carrier flag. A separate overrun scenario checks that the head byte survives while the newest entry is replaced.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RECV = 1'b1
  } rx_state_e;

  // queue entry: byte plus its parity status
  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              perr;
  } rx_item_t;

  localparam int ITEM_W = $bits(rx_item_t);

  // close cause, at most one bit set
  typedef struct packed {
    logic cd;
    logic ov;
    logic par;
  } close_cause_t;

endpackage

// File: rtl/bsr_hunt.sv
module bsr_hunt #(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             hunting,
  input  logic             carrier,
  input  logic             ext_sync,
  input  logic [1:0]       sync_mode,
  input  logic [PAT_W-1:0] sync_pat,
  output logic             sync_hit
);

  localparam int FILL_W  = $clog2(PAT_W + 1);
  localparam int SHORT_W = PAT_W / 4;
  localparam int MID_W   = PAT_W / 2;

  logic [PAT_W-2:0]  hist;
  logic [PAT_W-1:0]  hist_nx;
  logic [PAT_W-1:0]  aligned;
  logic [PAT_W-1:0]  mask;
  logic [FILL_W-1:0] fill;
  logic [FILL_W-1:0] fill_nx;
  logic [FILL_W-1:0] need;
  logic [FILL_W-1:0] drop;
  logic              pat_eq;

  always_comb begin
    // newest bit enters at the top, so the last N bits sit in the top N
    hist_nx = {rx_bit, hist};
    fill_nx = (fill == FILL_W'(PAT_W)) ? fill : fill + 1'b1;
    case (sync_mode)
      2'b01:   need = FILL_W'(SHORT_W);
      2'b10:   need = FILL_W'(MID_W);
      default: need = FILL_W'(PAT_W);
    endcase
    drop    = FILL_W'(PAT_W) - need;
    aligned = hist_nx >> drop;
    mask    = {PAT_W{1'b1}} >> drop;
    pat_eq  = ((aligned ^ sync_pat) & mask) == '0;
  end

  always_comb begin
    if (!hunting || !carrier)   sync_hit = 1'b0;
    else if (sync_mode == 2'b00) sync_hit = ext_sync;
    else                          sync_hit = bit_en && (fill_nx >= need) && pat_eq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !hunting) begin
      hist <= '0;
      fill <= '0;
    end else if (bit_en) begin
      hist <= hist_nx[PAT_W-1:1];
      fill <= fill_nx;
    end
  end

endmodule

// File: rtl/bsr_deser.sv
module bsr_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              active,
  input  logic              par_en,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_perr
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh;
  logic [CNT_W-1:0]  cnt;

  // first bit received ends up in bit 0
  assign byte_data = {rx_bit, sh};
  assign byte_done = active && bit_en && (cnt == LAST);
  assign byte_perr = par_en && !(^byte_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else if (bit_en) begin
      sh  <= byte_data[BYTE_W-1:1];
      cnt <= byte_done ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bsr_fifo.sv
module bsr_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         ovw,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic         full,
  output logic         valid,
  output logic [W-1:0] rdata
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] newest;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign newest = (wr_ptr == '0) ? PTR_LAST : wr_ptr - 1'b1;
  assign full   = (cnt == CNT_W'(DEPTH));
  assign valid  = (cnt != '0);
  assign rdata  = mem[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (push && wr_ptr == PTR_W'(i)) begin
        mem[i] <= wdata;
      end else if (!push && ovw && newest == PTR_W'(i)) begin
        mem[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/bsync_rx.sv
module bsync_rx #(
  parameter int PAT_W      = 16,
  parameter int FIFO_DEPTH = 2,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             carrier,
  input  logic             ext_sync,
  input  logic [1:0]       sync_mode,
  input  logic [PAT_W-1:0] sync_pat,
  input  logic             par_en,
  input  logic             int_en,
  input  logic             par_cnt_clr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_perr,
  output logic             frm_close,
  output logic             frm_cd,
  output logic             frm_ov,
  output logic             frm_par,
  output logic             rx_irq,
  output logic [CNT_W-1:0] par_cnt
);

  import bsr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  rx_state_e         state;
  logic              in_frame;
  logic              sync_hit;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_data;
  logic              byte_perr;
  logic              q_full;
  logic              q_pop;
  logic              q_push;
  logic              q_ovw;
  rx_item_t          q_in;
  rx_item_t          q_out;
  logic              cd_abort;
  logic              byte_ok;
  logic              par_fail;
  close_cause_t      cause;

  assign in_frame = (state == ST_RECV);

  bsr_hunt #(.PAT_W(PAT_W)) u_hunt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .hunting   (state == ST_HUNT),
    .carrier   (carrier),
    .ext_sync  (ext_sync),
    .sync_mode (sync_mode),
    .sync_pat  (sync_pat),
    .sync_hit  (sync_hit)
  );

  bsr_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .active    (in_frame),
    .par_en    (par_en),
    .byte_done (byte_done),
    .byte_data (byte_data),
    .byte_perr (byte_perr)
  );

  // error arbitration: carrier loss, then overrun, then parity
  always_comb begin
    cd_abort  = in_frame && !carrier;
    byte_ok   = byte_done && !cd_abort;
    q_pop     = out_valid && out_ready;
    q_ovw     = byte_ok && q_full && !q_pop;
    q_push    = byte_ok && !q_ovw;
    par_fail  = q_push && byte_perr;
    cause.cd  = cd_abort;
    cause.ov  = q_ovw;
    cause.par = par_fail;
    q_in.data = byte_data;
    q_in.perr = byte_perr;
  end

  bsr_fifo #(.DEPTH(FIFO_DEPTH), .W(ITEM_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .ovw   (q_ovw),
    .pop   (q_pop),
    .wdata (q_in),
    .full  (q_full),
    .valid (out_valid),
    .rdata (q_out)
  );

  assign out_data = q_out.data;
  assign out_perr = q_out.perr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_HUNT;
    end else if (cause != '0) begin
      state <= ST_HUNT;
    end else if (state == ST_HUNT && sync_hit) begin
      state <= ST_RECV;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_close <= 1'b0;
      frm_cd    <= 1'b0;
      frm_ov    <= 1'b0;
      frm_par   <= 1'b0;
      rx_irq    <= 1'b0;
    end else begin
      frm_close <= cause != '0;
      frm_cd    <= cause.cd;
      frm_ov    <= cause.ov;
      frm_par   <= cause.par;
      rx_irq    <= (cause != '0) && int_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || par_cnt_clr) begin
      par_cnt <= '0;
    end else if (par_fail && par_cnt != CNT_MAX) begin
      par_cnt <= par_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bsync_rx_chk.sv
module bsync_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             carrier,
  input logic             in_frame,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_perr,
  input logic             frm_close,
  input logic             frm_cd,
  input logic             frm_ov,
  input logic             frm_par,
  input logic             rx_irq,
  input logic             par_cnt_clr,
  input logic [CNT_W-1:0] par_cnt
);

  assert_one_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_close |-> $onehot({frm_cd, frm_ov, frm_par}));

  assert_no_stray_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_close |-> ({frm_cd, frm_ov, frm_par} == 3'b000));

  assert_close_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_close |=> !frm_close);

  assert_irq_with_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> frm_close);

  assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_perr)));

  assert_cd_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !carrier) |=> (frm_close && frm_cd));

  assert_hunt_after_close_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frm_close |-> !in_frame);

  assert_cnt_no_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !par_cnt_clr |=> (par_cnt >= $past(par_cnt)));

  assert_cnt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    par_cnt_clr |=> (par_cnt == '0));

endmodule

bind bsync_rx bsync_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .carrier     (carrier),
  .in_frame    (in_frame),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_perr    (out_perr),
  .frm_close   (frm_close),
  .frm_cd      (frm_cd),
  .frm_ov      (frm_ov),
  .frm_par     (frm_par),
  .rx_irq      (rx_irq),
  .par_cnt_clr (par_cnt_clr),
  .par_cnt     (par_cnt)
);

// File: tb/tb_bsync_rx.sv
`timescale 1ns/1ps
module tb_bsync_rx;

  localparam int PAT_W = 16;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_en = 1'b0;
  logic             rx_bit = 1'b0;
  logic             carrier = 1'b0;
  logic             ext_sync = 1'b0;
  logic [1:0]       sync_mode = 2'b10;
  logic [PAT_W-1:0] sync_pat = 16'h0016;
  logic             par_en = 1'b1;
  logic             int_en = 1'b1;
  logic             par_cnt_clr = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [7:0]       out_data;
  logic             out_perr;
  logic             frm_close;
  logic             frm_cd;
  logic             frm_ov;
  logic             frm_par;
  logic             rx_irq;
  logic [CNT_W-1:0] par_cnt;

  bsync_rx #(.PAT_W(PAT_W), .FIFO_DEPTH(2), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .carrier(carrier), .ext_sync(ext_sync), .sync_mode(sync_mode),
    .sync_pat(sync_pat), .par_en(par_en), .int_en(int_en),
    .par_cnt_clr(par_cnt_clr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_perr(out_perr), .frm_close(frm_close),
    .frm_cd(frm_cd), .frm_ov(frm_ov), .frm_par(frm_par), .rx_irq(rx_irq),
    .par_cnt(par_cnt)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [8:0] exp_q[$];    // {data, perr}
  logic [3:0] close_q[$];  // {cd, ov, par, irq}
  logic       exp_frame = 1'b0;
  logic [CNT_W-1:0] exp_cnt = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bad_par(input logic [7:0] b);
    return par_en && !(^b);
  endfunction

  // scoreboard monitor: samples between edges, inputs are stable here
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {out_data, out_perr}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({out_data, out_perr} == e, "R4/R6 byte stream", {out_data, out_perr}, e);
        end
      end
      if (frm_close) begin
        if (close_q.size() == 0) chk(1'b0, "R9 unexpected close", {frm_cd, frm_ov, frm_par, rx_irq}, 0);
        else begin
          logic [3:0] c;
          c = close_q.pop_front();
          chk({frm_cd, frm_ov, frm_par, rx_irq} == c, "R8/R9/R10 close flags",
              {frm_cd, frm_ov, frm_par, rx_irq}, c);
        end
      end
    end
  end

  task automatic tick_bit(input logic b, input logic drop_cd = 1'b0);
    @(negedge clk);
    rx_bit = b;
    bit_en = 1'b1;
    if (drop_cd) carrier = 1'b0;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_pat(input logic [15:0] p, input int n);
    for (int i = 0; i < n; i++) tick_bit(p[i]);
    exp_frame = 1'b1;
  endtask

  task automatic send_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) tick_bit(b[i]);
  endtask

  // driver: pushes the expected item, and a close on parity failure
  task automatic send_byte(input logic [7:0] b);
    logic pe;
    pe = bad_par(b);
    exp_q.push_back({b, pe});
    if (pe) begin
      close_q.push_back({3'b001, int_en});
      exp_frame = 1'b0;
      if (exp_cnt != CMAX) exp_cnt = exp_cnt + 1'b1;
    end
    send_raw(b);
  endtask

  task automatic drop_carrier();
    @(negedge clk);
    carrier = 1'b0;
    if (exp_frame) close_q.push_back({3'b100, int_en});
    exp_frame = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!frm_close && !rx_irq, "R1 close/irq", {frm_close, rx_irq}, 0);
    chk(par_cnt == '0, "R1 par_cnt", par_cnt, 0);

    // R2 8-bit pattern, R4 assembly timing, R8 carrier loss, R10 irq on
    carrier = 1'b1; sync_mode = 2'b10; sync_pat = 16'hFF16;
    send_pat(16'h0016, 8);
    send_byte(8'h01);
    chk(out_valid && out_data == 8'h01, "R4 byte right after 8th strobe", out_data, 8'h01);
    send_byte(8'h07);
    send_byte(8'h80);
    drop_carrier();

    // R2 4-bit pattern, upper pattern bits unused; R10 irq masked
    int_en = 1'b0; sync_mode = 2'b01; sync_pat = 16'hF0F6; carrier = 1'b1;
    send_pat(16'h0006, 4);
    send_byte(8'h0E);
    send_byte(8'hF1);
    drop_carrier();
    int_en = 1'b1;

    // R2 16-bit pattern, R6 parity failure, R12 no output without resync
    sync_mode = 2'b11; sync_pat = 16'h9C35; carrier = 1'b1;
    send_pat(16'h9C35, 16);
    send_byte(8'h52);
    send_byte(8'h03);
    send_raw(8'h00);
    send_raw(8'h00);
    idle(4);
    chk(!out_valid, "R12 no bytes after close without sync", out_valid, 0);
    chk(par_cnt == exp_cnt, "R6 counter increment", par_cnt, exp_cnt);
    drop_carrier();

    // R6 parity disabled
    par_en = 1'b0; sync_mode = 2'b10; sync_pat = 16'h0016; carrier = 1'b1;
    send_pat(16'h0016, 8);
    send_byte(8'h03);
    drop_carrier();
    chk(par_cnt == exp_cnt, "R6 no count when disabled", par_cnt, exp_cnt);
    par_en = 1'b1;

    // R3 external sync mode: line pattern ignored
    sync_mode = 2'b00; carrier = 1'b1;
    send_raw(8'h16);
    send_raw(8'h01);
    idle(3);
    chk(!out_valid, "R3 pattern ignored in external mode", out_valid, 0);
    @(negedge clk); ext_sync = 1'b1;
    @(negedge clk); ext_sync = 1'b0;
    exp_frame = 1'b1;
    send_byte(8'h25);
    drop_carrier();

    // R7 overrun with ready held low, R5 head hold
    sync_mode = 2'b10; sync_pat = 16'h0016; carrier = 1'b1; out_ready = 1'b0;
    send_pat(16'h0016, 8);
    exp_q.push_back({8'h01, 1'b0});
    send_raw(8'h01);
    send_raw(8'h02);
    exp_q.push_back({8'h04, 1'b0});
    close_q.push_back({3'b010, int_en});
    exp_frame = 1'b0;
    send_raw(8'h04);
    idle(2);
    chk(out_valid && out_data == 8'h01, "R5/R7 head kept under overrun", out_data, 8'h01);
    out_ready = 1'b1;
    idle(4);

    // R8 carrier loss on the completing strobe of an overrun/parity byte
    out_ready = 1'b0;
    send_pat(16'h0016, 8);
    exp_q.push_back({8'h01, 1'b0});
    send_raw(8'h01);
    exp_q.push_back({8'h02, 1'b0});
    send_raw(8'h02);
    for (int i = 0; i < 7; i++) tick_bit(1'(8'h03 >> i));
    close_q.push_back({3'b100, int_en});
    exp_frame = 1'b0;
    tick_bit(1'b0, 1'b1);
    idle(2);
    chk(par_cnt == exp_cnt, "R8 parity not counted under carrier loss", par_cnt, exp_cnt);
    out_ready = 1'b1;
    idle(4);

    // R11 saturation then clear
    carrier = 1'b1;
    for (int k = 0; k < 16; k++) begin
      send_pat(16'h0016, 8);
      send_byte(8'h03);
    end
    idle(3);
    chk(par_cnt == CMAX && exp_cnt == CMAX, "R11 saturate", par_cnt, CMAX);
    @(negedge clk); par_cnt_clr = 1'b1;
    @(negedge clk); par_cnt_clr = 1'b0;
    chk(par_cnt == '0, "R11 clear", par_cnt, 0);
    exp_cnt = '0;

    idle(6);
    chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    chk(close_q.size() == 0, "R9 all closes seen", close_q.size(), 0);
    done = 1'b1;
    report();
  end

endmodule